// File: doc/BRIEF.md
# Multi-rail power sequencing controller

This block is a synchronous state machine that brings up the supplies of a card carrying several multi-voltage devices, holds the processor in reset until those supplies have settled, and then supervises them. Its inputs are digital "good" flags produced by external voltage comparators. Two flags cover the card's 5 V and 3.3 V inputs. The others cover a 1.8 V processor core, a 1.5 V device core, the processor's 3.3 V I/O, a shared 3.3 V I/O rail and a 2.5 V core. Its outputs drive the regulator and switch enables, a switch that shorts the processor's I/O rail to its core, the processor reset and a card-healthy status.

The power-up order works as follows:
- Both cores start together.
- The shared 3.3 V switch closes only after both cores report good.
- The 2.5 V supply starts only after the shared 3.3 V rail reports good.
- A reset stretch then runs before the card is declared healthy.

If any supply is lost while the card is running or stretching its reset, the controller takes a tracked power-down. It re-asserts reset, opens every enable except the 1.8 V one and closes the shorting switch. It then waits for the I/O decoupling to drain and drops the 1.8 V core last. Every wait for a good flag is bounded by a timeout, and when the timeout expires the controller takes the same power-down path. All delays are counted in clock cycles.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset, and whenever the controller is idle, all enables (`en_1v8`, `en_1v5`, `en_3v3`, `en_2v5`, `en_short`) are low, `cpu_rst` is high and `card_ok` is low. The controller leaves idle only in a cycle where both `in5_ok` and `in33_ok` are high.
- R2: Leaving idle raises `en_1v8` and `en_1v5` together in the cycle after both input flags are seen high.
- R3: `en_3v3` rises only in the cycle after `core18_ok` and `core15_ok` are both seen high while the core step is active.
- R4: `en_2v5` rises only in the cycle after `io33_ok` is seen high while the shared 3.3 V step is active.
- R5: The reset stretch starts in the cycle after `core25_ok`, `cpu33_ok` and `core18_ok` are all seen high during the 2.5 V step. `cpu_rst` stays high through every power-up step and through exactly STRETCH_CYC cycles of stretch.
- R6: After the stretch, `cpu_rst` goes low and `card_ok` goes high. The two are never high together.
- R7: If any of the seven good flags is low in a cycle during the stretch or normal running, then in the next cycle several outputs change together: `cpu_rst` is high, `card_ok` is low, `en_1v5`, `en_2v5` and `en_3v3` are low, `en_short` is high and `en_1v8` stays high.
- R8: The power-down holds `en_1v8` and `en_short` high for exactly DISCHG_CYC cycles. Both then go low together, and the controller returns to idle.
- R9: If an awaited flag set does not arrive within TMO_CYC cycles of entering the core, shared 3.3 V or 2.5 V step, the controller enters the power-down path.
- R10: Losing `in5_ok` or `in33_ok` during any power-up step sends the controller into the power-down path in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in5_ok | input | 1 | Card 5 V input good |
| in33_ok | input | 1 | Card 3.3 V input good |
| core18_ok | input | 1 | Processor 1.8 V core good |
| core15_ok | input | 1 | Device 1.5 V core good |
| cpu33_ok | input | 1 | Processor 3.3 V I/O good |
| io33_ok | input | 1 | Shared 3.3 V I/O good |
| core25_ok | input | 1 | 2.5 V core good |
| en_1v8 | output | 1 | 1.8 V regulator enable |
| en_1v5 | output | 1 | 1.5 V core switch enable |
| en_3v3 | output | 1 | Shared 3.3 V switch enable (processor and device I/O) |
| en_2v5 | output | 1 | 2.5 V converter enable |
| en_short | output | 1 | I/O-to-core shorting switch enable |
| cpu_rst | output | 1 | Processor reset, active high |
| card_ok | output | 1 | Card healthy status |

## Verification
Two situations are hardest to reach from the ports. The first is a fault that lands during the reset stretch rather than in normal running. The bench reaches it by bringing every flag up and then pulling one down a few cycles into the stretch window. The second is the timeout path, which needs a flag that never comes. It is reached as a by-product of a completed power-down: the rail flags stay low while the card inputs remain good, so the controller restarts, waits in the core step and must time out. Losing a card input in the middle of the shared 3.3 V step covers the remaining abort path.

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl #(
  parameter int STRETCH_CYC = 15000000,
  parameter int DISCHG_CYC  = 1000000,
  parameter int TMO_CYC     = 2500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in5_ok,
  input  logic in33_ok,
  input  logic core18_ok,
  input  logic core15_ok,
  input  logic cpu33_ok,
  input  logic io33_ok,
  input  logic core25_ok,
  output logic en_1v8,
  output logic en_1v5,
  output logic en_3v3,
  output logic en_2v5,
  output logic en_short,
  output logic cpu_rst,
  output logic card_ok
);
  localparam int MAXC = (STRETCH_CYC > DISCHG_CYC) ?
                        ((STRETCH_CYC > TMO_CYC) ? STRETCH_CYC : TMO_CYC) :
                        ((DISCHG_CYC > TMO_CYC) ? DISCHG_CYC : TMO_CYC);
  localparam int CW = $clog2(MAXC + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_CORE, S_IO, S_R25, S_STR, S_RUN, S_SHUT
  } st_t;

  st_t st, nxt;
  logic [CW-1:0] cnt;

  wire in_ok  = in5_ok & in33_ok;
  wire all_ok = in_ok & core18_ok & core15_ok & cpu33_ok & io33_ok & core25_ok;
  wire tmo    = (cnt == CW'(TMO_CYC - 1));

  always_comb begin
    nxt = st;
    case (st)
      S_IDLE: if (in_ok) nxt = S_CORE;
      S_CORE: if (!in_ok) nxt = S_SHUT;
              else if (core18_ok && core15_ok) nxt = S_IO;
              else if (tmo) nxt = S_SHUT;
      S_IO:   if (!in_ok) nxt = S_SHUT;
              else if (io33_ok) nxt = S_R25;
              else if (tmo) nxt = S_SHUT;
      S_R25:  if (!in_ok) nxt = S_SHUT;
              else if (core25_ok && cpu33_ok && core18_ok) nxt = S_STR;
              else if (tmo) nxt = S_SHUT;
      S_STR:  if (!all_ok) nxt = S_SHUT;
              else if (cnt == CW'(STRETCH_CYC - 1)) nxt = S_RUN;
      S_RUN:  if (!all_ok) nxt = S_SHUT;
      S_SHUT: if (cnt == CW'(DISCHG_CYC - 1)) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else begin
      st <= nxt;
      if (nxt != st || st == S_IDLE || st == S_RUN) cnt <= '0;
      else cnt <= cnt + 1'b1;
    end
  end

  assign en_1v8   = (st != S_IDLE);
  assign en_1v5   = (st != S_IDLE) && (st != S_SHUT);
  assign en_3v3   = (st == S_IO) || (st == S_R25) || (st == S_STR) || (st == S_RUN);
  assign en_2v5   = (st == S_R25) || (st == S_STR) || (st == S_RUN);
  assign en_short = (st == S_SHUT);
  assign cpu_rst  = (st != S_RUN);
  assign card_ok  = (st == S_RUN);
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic in5_ok,
  input logic in33_ok,
  input logic core18_ok,
  input logic core15_ok,
  input logic cpu33_ok,
  input logic io33_ok,
  input logic core25_ok,
  input logic en_1v8,
  input logic en_1v5,
  input logic en_3v3,
  input logic en_2v5,
  input logic en_short,
  input logic cpu_rst,
  input logic card_ok
);
  wire flags_ok = in5_ok && in33_ok && core18_ok && core15_ok && cpu33_ok && io33_ok && core25_ok;

  AST_CORE_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_1v8) |-> $past(in5_ok && in33_ok)); // R1
  AST_CORE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_1v8) |-> en_1v5); // R2
  AST_IO_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_3v3) |-> $past(core18_ok && core15_ok)); // R3
  AST_R25_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_2v5) |-> $past(io33_ok)); // R4
  AST_RST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (en_1v8 && !card_ok) |-> cpu_rst); // R5
  AST_OK_NORST: assert property (@(posedge clk) disable iff (!rst_n)
    card_ok |-> !cpu_rst); // R6
  AST_FAULT_REACT: assert property (@(posedge clk) disable iff (!rst_n)
    (card_ok && !flags_ok) |=> (cpu_rst && !card_ok && en_short && en_1v8)); // R7
  AST_SHORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    en_short |-> (en_1v8 && !en_1v5 && !en_3v3 && !en_2v5)); // R7
  AST_CORE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_1v8) |-> $past(en_short)); // R8
endmodule

bind pwr_seq_ctrl pwr_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in5_ok(in5_ok), .in33_ok(in33_ok),
  .core18_ok(core18_ok), .core15_ok(core15_ok), .cpu33_ok(cpu33_ok),
  .io33_ok(io33_ok), .core25_ok(core25_ok), .en_1v8(en_1v8), .en_1v5(en_1v5),
  .en_3v3(en_3v3), .en_2v5(en_2v5), .en_short(en_short), .cpu_rst(cpu_rst),
  .card_ok(card_ok)
);

// File: tb/sim_pwr_seq_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_seq_ctrl;
  localparam int STR = 20;
  localparam int DIS = 6;
  localparam int TMO = 8;

  logic clk = 0, rst_n = 0;
  logic in5_ok = 0, in33_ok = 0, core18_ok = 0, core15_ok = 0;
  logic cpu33_ok = 0, io33_ok = 0, core25_ok = 0;
  logic en_1v8, en_1v5, en_3v3, en_2v5, en_short, cpu_rst, card_ok;

  int checks = 0, failures = 0, cycles = 0;
  string req = "R1";

  always #2 clk = ~clk;

  pwr_seq_ctrl #(.STRETCH_CYC(STR), .DISCHG_CYC(DIS), .TMO_CYC(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .in5_ok(in5_ok), .in33_ok(in33_ok),
    .core18_ok(core18_ok), .core15_ok(core15_ok), .cpu33_ok(cpu33_ok),
    .io33_ok(io33_ok), .core25_ok(core25_ok), .en_1v8(en_1v8), .en_1v5(en_1v5),
    .en_3v3(en_3v3), .en_2v5(en_2v5), .en_short(en_short), .cpu_rst(cpu_rst),
    .card_ok(card_ok)
  );

  // reference model: phase 0 idle,1 cores,2 shared io,3 2v5,4 stretch,5 run,6 power-down
  int ph = 0, dwell = 0;
  always @(posedge clk) begin
    int np;
    bit inp, all;
    inp = in5_ok && in33_ok;
    all = inp && core18_ok && core15_ok && cpu33_ok && io33_ok && core25_ok;
    np = ph;
    if (!rst_n) np = 0;
    else if (ph == 0) begin if (inp) np = 1; end
    else if (ph >= 1 && ph <= 3) begin
      if (!inp) np = 6;
      else if (ph == 1 && core18_ok && core15_ok) np = 2;
      else if (ph == 2 && io33_ok) np = 3;
      else if (ph == 3 && core25_ok && cpu33_ok && core18_ok) np = 4;
      else if (dwell + 1 >= TMO) np = 6;
    end
    else if (ph == 4) begin
      if (!all) np = 6; else if (dwell + 1 >= STR) np = 5;
    end
    else if (ph == 5) begin if (!all) np = 6; end
    else if (dwell + 1 >= DIS) np = 0;
    dwell = (np != ph) ? 0 : dwell + 1;
    ph = np;
  end

  function automatic logic [6:0] expect_out(int p);
    case (p)
      0: return 7'b0000010;
      1: return 7'b1100010;
      2: return 7'b1110010;
      3, 4: return 7'b1111010;
      5: return 7'b1111001;
      default: return 7'b1000110;
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      logic [6:0] got, exp;
      got = {en_1v8, en_1v5, en_3v3, en_2v5, en_short, cpu_rst, card_ok};
      exp = expect_out(ph);
      checks++;
      if (got !== exp) begin
        failures++;
        $display("FAIL %s cycle %0d outputs got %b expected %b", req, cycles, got, exp);
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic rails(logic v);
    core18_ok = v; core15_ok = v; cpu33_ok = v; io33_ok = v; core25_ok = v;
  endtask

  initial begin
    cyc(3);
    rst_n = 1;
    req = "R1"; cyc(5);
    in5_ok = 1; cyc(4);                     // R1: one input is not enough
    req = "R2"; in33_ok = 1; cyc(3);        // cores step, flags absent
    req = "R3"; core18_ok = 1; cyc(1); core15_ok = 1; cyc(3);
    req = "R4"; io33_ok = 1; cyc(3);
    req = "R5"; cpu33_ok = 1; cyc(2); core25_ok = 1; cyc(STR + 2);
    req = "R6"; cyc(5);
    req = "R7"; core25_ok = 0; cyc(2);
    req = "R8"; rails(0); cyc(DIS + 1);
    req = "R9"; cyc(TMO + DIS + 2);         // restart with rails missing times out
    in5_ok = 0; in33_ok = 0; cyc(TMO + DIS + 4);
    req = "R10"; in5_ok = 1; in33_ok = 1; core18_ok = 1; core15_ok = 1; cyc(4);
    in33_ok = 0; cyc(DIS + 3);
    req = "R7"; in33_ok = 1; rails(1); cyc(6);
    cpu33_ok = 0; cyc(DIS + 3);             // fault inside the stretch window
    in5_ok = 0; rails(0); cyc(DIS + TMO + 4);
    req = "R9"; in5_ok = 1; core18_ok = 1; core15_ok = 1; cyc(3);
    cyc(TMO + 2);                           // io33 never arrives
    in5_ok = 0; cyc(DIS + 4);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule